// File: doc/BRIEF.md
# Priority Interrupt Controller with Selectable Preemption

The controller watches a vector of interrupt request lines and offers the processor one request at a time, always the pending line with the best fixed priority. Line 0 ranks highest, and the rank falls as the line index rises. A request line is sampled on every clock. Once it is seen high, it is held in a pending register until the processor takes that request, so a source may pulse its line for a single cycle. The offered request is given as a valid flag and the binary index of the line. The processor takes the request with an acknowledge strobe and reports the end of the running service routine with an end-of-service strobe.

A mode input selects the service policy while the block runs. With run-to-end policy, nothing is offered while a routine is in service. Every pending line, old or new, is then rescanned when the routine ends. With preemptive policy, a pending line of strictly better rank than the level in service is offered at once. The interrupted levels are kept in an in-service bit vector that acts as a nesting stack. End of service retires the best-ranked level, and the level it interrupted becomes current again. When the last level retires and nothing is pending, a one-cycle pulse tells the processor that the interrupted user program may resume.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted, and for the cycles after it that the reset synchronizer holds, `req_valid` and `user_resume` are 0.
- R2: A request line that is high for one clock edge becomes pending. It stays pending after the line drops until that request is acknowledged.
- R3: When no level is in service, `req_valid` is 1 exactly when some line is pending. `req_id` is then the binary index of the lowest-numbered pending line, where index 0 is the highest priority.
- R4: An `ack` sampled while `req_valid` is 1 clears the pending bit of line `req_id` and marks that line in service. An `ack` sampled while `req_valid` is 0 changes nothing.
- R5: With `preempt_en` = 0 (run-to-end policy), `req_valid` stays 0 while any level is in service, whatever the priority of the pending lines.
- R6: With `preempt_en` = 1, `req_valid` is 1 while a level is in service only when the best pending line has a strictly lower index than the best in-service level. Equal or lower-ranked lines stay pending and are not offered.
- R7: An `eos` strobe retires only the best-ranked in-service level. The level it interrupted becomes current again, and the preemption test of R6 is then made against that level.
- R8: After an `eos`, all pending lines are rescanned, including those that arrived during the routine, and they are offered one by one in priority order.
- R9: `user_resume` is 1 for exactly one cycle. It rises in the cycle after an `eos` that leaves no level in service and no line pending, and it never rises while a line is pending or a level is in service.
- R10: An `eos` sampled while no level is in service is ignored and gives no `user_resume` pulse.
- R11: If a line goes high in the same cycle as the `eos` that retires the last level, there is no `user_resume` pulse, and that line is offered in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | NUM_LINES | Level-sampled request lines; bit 0 has the highest priority |
| preempt_en | input | 1 | 1 selects preemptive policy, 0 selects run-to-end policy |
| ack | input | 1 | Processor takes the offered request |
| eos | input | 1 | Processor ends the running service routine |
| req_valid | output | 1 | A request is offered |
| req_id | output | IDW | Binary index of the offered line |
| user_resume | output | 1 | One-cycle pulse: user program may resume |

## Verification
The end-of-service strobe that retires the last level can land in the same cycle as a new request line rising. In that cycle the resume decision and the pending capture collide. The bench provokes this by driving `eos` and a fresh request line together. It passes only if no resume pulse appears and the new line is offered on the very next cycle. A second collision is a preempting request arriving while the level it would preempt retires; the bench runs it as a nested end of service, followed by a request ranked between the retired level and the restored one.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  // Service policy carried by the mode input.
  typedef enum logic {
    POLICY_RUN_TO_END = 1'b0,
    POLICY_PREEMPT    = 1'b1
  } policy_e;
endpackage

// File: rtl/irq_prio_rst_sync.sv
module irq_prio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_prio_pick.sv
// Finds the lowest set index of a vector (lowest index = best rank).
module irq_prio_pick #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  assign onehot = vec & (~vec + {{(N-1){1'b0}}, 1'b1});
endmodule

// File: rtl/irq_prio_inservice.sv
// Nesting stack held as an in-service bit vector.
module irq_prio_inservice #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  set_oh,
  input  logic          retire,
  output logic [N-1:0]  isr_q,
  output logic [N-1:0]  isr_next,
  output logic          cur_any,
  output logic [IW-1:0] cur_idx
);
  logic [N-1:0] cur_oh;
  logic         isr_en;

  irq_prio_pick #(.N(N)) u_cur_pick (
    .vec    (isr_q),
    .found  (cur_any),
    .idx    (cur_idx),
    .onehot (cur_oh)
  );

  always_comb begin
    isr_next = isr_q;
    if (retire) isr_next = isr_next & ~cur_oh;
    isr_next = isr_next | set_oh;
    isr_en   = retire | (|set_oh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      isr_q <= '0;
    else if (isr_en) isr_q <= isr_next;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned IDW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 preempt_en,
  input  logic                 ack,
  input  logic                 eos,
  output logic                 req_valid,
  output logic [IDW-1:0]       req_id,
  output logic                 user_resume
);
  logic                 rst_sn;
  logic [NUM_LINES-1:0] pend_q, pend_d;
  logic                 pend_en;
  logic                 pend_any;
  logic [IDW-1:0]       pend_idx;
  logic [NUM_LINES-1:0] pend_oh;
  logic [NUM_LINES-1:0] isr_q, isr_next, set_oh;
  logic                 cur_any;
  logic [IDW-1:0]       cur_idx;
  logic                 take;
  logic                 resume_d;
  policy_e              policy;

  irq_prio_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sn)
  );

  irq_prio_pick #(.N(NUM_LINES)) u_pend_pick (
    .vec    (pend_q),
    .found  (pend_any),
    .idx    (pend_idx),
    .onehot (pend_oh)
  );

  irq_prio_inservice #(.N(NUM_LINES)) u_isr (
    .clk      (clk),
    .rst_n    (rst_sn),
    .set_oh   (set_oh),
    .retire   (eos),
    .isr_q    (isr_q),
    .isr_next (isr_next),
    .cur_any  (cur_any),
    .cur_idx  (cur_idx)
  );

  // Offer decision and next-state logic.
  always_comb begin
    policy = policy_e'(preempt_en);
    if (!cur_any)                     req_valid = pend_any;
    else if (policy == POLICY_PREEMPT) req_valid = pend_any && (pend_idx < cur_idx);
    else                              req_valid = 1'b0;
    req_id  = pend_idx;
    take    = ack & req_valid;
    set_oh  = take ? pend_oh : '0;
    pend_d  = (pend_q | irq_in) & ~set_oh;
    pend_en = (|irq_in) | take;
    resume_d = eos & cur_any & ~(|isr_next) & ~(|pend_d);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pend_q      <= '0;
      user_resume <= 1'b0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      user_resume <= resume_d;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned IDW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                 clk,
  input logic                 rst_sn,
  input logic                 preempt_en,
  input logic                 ack,
  input logic                 eos,
  input logic                 req_valid,
  input logic [IDW-1:0]       req_id,
  input logic                 user_resume,
  input logic [NUM_LINES-1:0] pend_q,
  input logic [NUM_LINES-1:0] isr_q,
  input logic                 cur_any,
  input logic [IDW-1:0]       cur_idx
);
  p_offer_is_pending_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    req_valid |-> pend_q[req_id]);

  p_ack_enters_service_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (ack && req_valid) |=> isr_q[$past(req_id)]);

  p_ack_clears_pending_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (ack && req_valid) |=> !pend_q[$past(req_id)]);

  p_run_to_end_hold_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (!preempt_en && cur_any) |-> !req_valid);

  p_strict_preempt_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid && cur_any) |-> (req_id < cur_idx));

  p_resume_single_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    user_resume |=> !user_resume);

  p_resume_idle_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    user_resume |-> (isr_q == '0 && pend_q == '0));

  p_idle_eos_ignored_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (eos && !cur_any) |=> !user_resume);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk         (clk),
  .rst_sn      (rst_sn),
  .preempt_en  (preempt_en),
  .ack         (ack),
  .eos         (eos),
  .req_valid   (req_valid),
  .req_id      (req_id),
  .user_resume (user_resume),
  .pend_q      (pend_q),
  .isr_q       (isr_q),
  .cur_any     (cur_any),
  .cur_idx     (cur_idx)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL  = 8;
  localparam int IDW = 3;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NL-1:0]  irq_in;
  logic           preempt_en, ack, eos;
  logic           req_valid, user_resume;
  logic [IDW-1:0] req_id;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl #(.NUM_LINES(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .preempt_en(preempt_en),
    .ack(ack), .eos(eos), .req_valid(req_valid), .req_id(req_id),
    .user_resume(user_resume)
  );

  // Inputs change and outputs are sampled 1 time unit after a rising edge.
  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_offer(input string tag, input int v, input int id);
    chk({tag, " valid"}, int'(req_valid), v);
    if (v == 1) chk({tag, " id"}, int'(req_id), id);
  endtask

  task automatic raise(input logic [NL-1:0] m);
    irq_in = m; cyc(); irq_in = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1; cyc(); ack = 1'b0;
  endtask

  task automatic do_eos();
    eos = 1'b1; cyc(); eos = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; irq_in = '0; preempt_en = 1'b0; ack = 1'b0; eos = 1'b0;
    repeat (3) cyc();
    chk("R1 in reset valid", int'(req_valid), 0);
    chk("R1 in reset resume", int'(user_resume), 0);
    rst_n = 1'b1;
    repeat (3) cyc();
    chk("R1 after release valid", int'(req_valid), 0);
    chk("R1 after release resume", int'(user_resume), 0);
  endtask

  task automatic t_run_to_end();
    preempt_en = 1'b0;
    raise(8'h48);
    chk_offer("R2 R3 pulse latched best line", 1, 3);
    do_ack();
    chk_offer("R5 lower line held", 0, 0);
    raise(8'h01);
    chk_offer("R5 better line held", 0, 0);
    do_eos();
    chk("R9 no resume while pending", int'(user_resume), 0);
    chk_offer("R8 rescan picks line 0", 1, 0);
    do_ack(); do_eos();
    chk_offer("R8 rescan picks line 6", 1, 6);
    chk("R9 no resume line 6 pending", int'(user_resume), 0);
    do_ack(); do_eos();
    chk("R9 resume pulse", int'(user_resume), 1);
    cyc();
    chk("R9 resume one cycle", int'(user_resume), 0);
    chk_offer("R3 idle", 0, 0);
  endtask

  task automatic t_ignored();
    preempt_en = 1'b0;
    do_ack();
    do_eos();
    chk("R4 R10 stray ack/eos no resume", int'(user_resume), 0);
    raise(8'h10);
    chk_offer("R4 offer after stray ack", 1, 4);
    do_ack(); do_eos();
    chk("R4 real service resumes", int'(user_resume), 1);
    cyc();
  endtask

  task automatic t_preempt();
    preempt_en = 1'b1;
    raise(8'h20);
    do_ack();
    raise(8'h80);
    chk_offer("R6 lower rank no preempt", 0, 0);
    raise(8'h20);
    chk_offer("R6 equal rank no preempt", 0, 0);
    raise(8'h04);
    chk_offer("R6 better rank preempts", 1, 2);
    do_ack();
    chk_offer("R6 nested none better", 0, 0);
    do_eos();
    chk("R7 nested eos no resume", int'(user_resume), 0);
    chk_offer("R7 level 5 restored", 0, 0);
    raise(8'h08);
    chk_offer("R7 line 3 beats restored 5", 1, 3);
    do_ack(); do_eos();
    do_eos();
    chk("R9 pending blocks resume", int'(user_resume), 0);
    chk_offer("R8 pending line 5 next", 1, 5);
    do_ack(); do_eos();
    chk_offer("R8 pending line 7 next", 1, 7);
    do_ack(); do_eos();
    chk("R9 preemptive resume", int'(user_resume), 1);
    cyc();
    chk("R9 pulse ends", int'(user_resume), 0);
  endtask

  task automatic t_same_cycle();
    preempt_en = 1'b0;
    raise(8'h02);
    do_ack();
    irq_in = 8'h10; eos = 1'b1; cyc(); irq_in = '0; eos = 1'b0;
    chk("R11 no resume on collision", int'(user_resume), 0);
    chk_offer("R11 new line offered", 1, 4);
    do_ack(); do_eos();
    chk("R11 resume after new line", int'(user_resume), 1);
    cyc();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_run_to_end();
    t_ignored();
    t_preempt();
    t_same_cycle();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule